// File: doc/BRIEF.md
# Reed-Solomon Symbol Correction Applier

This block sits after a Reed-Solomon error locator. It takes up to four symbol error positions with their 12-bit error values and folds them into a byte buffer that holds one flash page: the data area first, then the spare area directly after it. The page is read as a run of 12-bit symbols packed back to back, so most symbols straddle a byte boundary. Each error turns into byte-address/XOR-mask writes (one for symbol 0, two for every other symbol). The buffer XORs each mask into the addressed byte.

All entries are checked before the first write. If any entry cannot be mapped, or more than four errors are reported, the whole page is declared uncorrectable: the buffer is left untouched, the fail flag is raised and the count stays zero. After a clean pass the block reports how many symbols it corrected. A host port loads the page into the buffer and reads the corrected bytes back.

Top module: `rsfix_applier`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o`, `fix_we_o` are 0 and `corr_cnt_o` is 0.
- R2: A position above the last correctable symbol MAX_POS = floor(2·(DATA_BYTES+ECC_BYTES)/3) (1374 by default) makes the page uncorrectable.
- R3: At position 0 only the low 8 bits of the value are meaningful. A value above 0xFF makes the page uncorrectable. Otherwise exactly one write XORs value[7:0] into byte 0.
- R4: For an odd position p, byte floor(3p/2) is XORed with value[11:4], and the following byte with value[3:0] placed in bits 7:4.
- R5: For an even position p ≥ 2, byte 3p/2−1 is XORed with value[11:8] in bits 3:0, and byte 3p/2 with value[7:0].
- R6: Spare byte k sits at buffer address DATA_BYTES+k. The symbol floor(2·DATA_BYTES/3) (1365 by default) splits: value[11:4] goes to the last data byte and value[3:0] goes to bits 7:4 of spare byte 0.
- R7: An error count above four makes the page uncorrectable.
- R8: An uncorrectable page changes no buffer byte and emits no write. It ends with `fail_o`=1 and `corr_cnt_o`=0.
- R9: `done_o` pulses for one cycle at the end of every job, and `busy_o` is then 0. On success `fail_o`=0 and `corr_cnt_o` equals the error count, including zero. Both outputs hold until the next start.
- R10: With start sampled at edge k, the writes appear one per cycle, in entry order, on the cycles after edges k+1 … k+W. W is the number of writes. The two writes of a symbol come on consecutive cycles, lower address first. `done_o` is high after edge k+W+1, so a failed or empty job finishes after edge k+1.
- R11: While busy, host writes and new start pulses are ignored.
- R12: `host_rdata_o` shows the byte at `host_addr_i` one clock after the address is presented.
- R13: Several errors that touch the same byte all accumulate by XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a correction job with the error list below |
| err_cnt_i | input | CNT_W | Number of valid error entries |
| err_pos_i | input | MAX_ERR·POS_W | Symbol positions, entry i at bits i·POS_W upward |
| err_pat_i | input | MAX_ERR·12 | Error values, entry i at bits i·12 upward |
| host_we_i | input | 1 | Host byte write enable |
| host_addr_i | input | AW | Host byte address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Registered host read data |
| fix_we_o | output | 1 | A correction write is applied this cycle |
| fix_addr_o | output | AW | Byte address of the correction write |
| fix_mask_o | output | 8 | XOR mask of the correction write |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| fail_o | output | 1 | Last job was uncorrectable |
| corr_cnt_o | output | CNT_W | Symbols corrected by the last job |

## Verification
The bench builds the block with a 32-byte data area, 14 ECC bytes and a 16-byte spare area. That makes MAX_POS 30 and the straddling symbol 21, and the whole buffer is 48 bytes. It sweeps every position from 0 past the correctable limit, which covers both parities, symbol 0, the split across the data/spare boundary and the first out-of-range position. After each job it reads back the whole buffer. Multi-error jobs cover entry ordering, overlapping bytes, excess counts and a late bad entry that must prevent every earlier write.

// File: rtl/rsfix_pkg.sv
`timescale 1ns/1ps
package rsfix_pkg;

    localparam int SYM_W  = 12;
    localparam int BYTE_W = 8;
    localparam int MAP_AW = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RUN
    } rsfix_state_e;

    // One symbol mapped onto its byte writes
    typedef struct packed {
        logic              bad;
        logic              single;
        logic [MAP_AW-1:0] addr_a;
        logic [BYTE_W-1:0] mask_a;
        logic [MAP_AW-1:0] addr_b;
        logic [BYTE_W-1:0] mask_b;
    } rsfix_map_t;

    // Map a 12-bit symbol position onto the flat byte space (spare follows data)
    function automatic rsfix_map_t rsfix_map(input logic [MAP_AW-1:0] pos,
                                             input logic [SYM_W-1:0]  pat,
                                             input logic [MAP_AW-1:0] max_pos);
        rsfix_map_t        m;
        logic [MAP_AW+1:0] base;
        base = (MAP_AW+2)'((18'(pos) * 18'd3) >> 1);
        m = '0;
        m.bad = (pos > max_pos);
        if (pos == '0) begin
            m.single = 1'b1;
            m.bad    = m.bad | (pat[11:8] != 4'h0);
            m.addr_a = '0;
            m.mask_a = pat[7:0];
        end else if (pos[0]) begin
            m.addr_a = base[MAP_AW-1:0];
            m.mask_a = pat[11:4];
            m.addr_b = MAP_AW'(base + 18'd1);
            m.mask_b = {pat[3:0], 4'h0};
        end else begin
            m.addr_a = MAP_AW'(base - 18'd1);
            m.mask_a = {4'h0, pat[11:8]};
            m.addr_b = base[MAP_AW-1:0];
            m.mask_b = pat[7:0];
        end
        return m;
    endfunction

endpackage

// File: rtl/rsfix_check.sv
`timescale 1ns/1ps
module rsfix_check
    import rsfix_pkg::*;
#(
    parameter int MAX_ERR = 4,
    parameter int POS_W   = 11,
    parameter int CNT_W   = 3,
    parameter int MAX_POS = 1374
) (
    input  logic [CNT_W-1:0]           cnt_i,
    input  logic [MAX_ERR*POS_W-1:0]   pos_i,
    input  logic [MAX_ERR*SYM_W-1:0]   pat_i,
    output rsfix_map_t                 maps_o [MAX_ERR],
    output logic                       page_bad_o
);

    logic [MAX_ERR-1:0] bad_vec;

    for (genvar g = 0; g < MAX_ERR; g++) begin : g_entry
        assign maps_o[g]  = rsfix_map(MAP_AW'(pos_i[g*POS_W +: POS_W]),
                                      pat_i[g*SYM_W +: SYM_W],
                                      MAP_AW'(MAX_POS));
        assign bad_vec[g] = (g < 32'(cnt_i)) && maps_o[g].bad;
    end

    assign page_bad_o = (|bad_vec) || (32'(cnt_i) > MAX_ERR);

endmodule

// File: rtl/rsfix_ctrl.sv
`timescale 1ns/1ps
module rsfix_ctrl
    import rsfix_pkg::*;
#(
    parameter int MAX_ERR = 4,
    parameter int POS_W   = 11,
    parameter int CNT_W   = 3,
    parameter int AW      = 12,
    parameter int TOTAL   = 2112
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [CNT_W-1:0]          cnt_i,
    input  logic [MAX_ERR*POS_W-1:0]  pos_i,
    input  logic [MAX_ERR*SYM_W-1:0]  pat_i,
    output logic [CNT_W-1:0]          cnt_q_o,
    output logic [MAX_ERR*POS_W-1:0]  pos_q_o,
    output logic [MAX_ERR*SYM_W-1:0]  pat_q_o,
    input  rsfix_map_t                maps_i [MAX_ERR],
    input  logic                      page_bad_i,
    output logic                      fix_we_o,
    output logic [AW-1:0]             fix_addr_o,
    output logic [BYTE_W-1:0]         fix_mask_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      fail_o,
    output logic [CNT_W-1:0]          corr_cnt_o
);

    localparam int IDX_W = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

    rsfix_state_e      state;
    logic [IDX_W-1:0]  idx;
    logic              half;
    rsfix_map_t        cur;
    logic              last;
    logic [MAP_AW-1:0] cur_addr;

    assign cur      = maps_i[idx];
    assign last     = (32'(idx) + 1) == 32'(cnt_q_o);
    assign cur_addr = half ? cur.addr_b : cur.addr_a;

    assign fix_we_o   = (state == ST_RUN);
    assign fix_addr_o = cur_addr[AW-1:0];
    assign fix_mask_o = half ? cur.mask_b : cur.mask_a;
    assign busy_o     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            idx        <= '0;
            half       <= 1'b0;
            done_o     <= 1'b0;
            fail_o     <= 1'b0;
            corr_cnt_o <= '0;
            cnt_q_o    <= '0;
            pos_q_o    <= '0;
            pat_q_o    <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        cnt_q_o    <= cnt_i;
                        pos_q_o    <= pos_i;
                        pat_q_o    <= pat_i;
                        fail_o     <= 1'b0;
                        corr_cnt_o <= '0;
                        state      <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    idx  <= '0;
                    half <= 1'b0;
                    if (page_bad_i) begin
                        fail_o <= 1'b1;
                        done_o <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (cnt_q_o == '0) begin
                        done_o <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (!half && !cur.single) begin
                        half <= 1'b1;
                    end else if (last) begin
                        corr_cnt_o <= cnt_q_o;
                        done_o     <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        idx  <= idx + IDX_W'(1);
                        half <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_fail_no_count: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> (corr_cnt_o == '0));

    a_r2_bad_page_no_write: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && page_bad_i) |=> !fix_we_o);

    a_r4_addr_in_buffer: assert property (@(posedge clk) disable iff (rst)
        fix_we_o |-> (32'(cur_addr) < TOTAL));

    a_r10_pair_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (fix_we_o && !half && !cur.single) |=> fix_we_o);

endmodule

// File: rtl/rsfix_buf.sv
`timescale 1ns/1ps
module rsfix_buf
    import rsfix_pkg::*;
#(
    parameter int TOTAL = 2112,
    parameter int AW    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic              fix_we_i,
    input  logic [AW-1:0]     fix_addr_i,
    input  logic [BYTE_W-1:0] fix_mask_i,
    input  logic              host_we_i,
    input  logic [AW-1:0]     host_addr_i,
    input  logic [BYTE_W-1:0] host_wdata_i,
    output logic [BYTE_W-1:0] host_rdata_o
);

    logic [BYTE_W-1:0] mem [TOTAL];

    always_ff @(posedge clk) begin
        if (fix_we_i) begin
            mem[fix_addr_i] <= mem[fix_addr_i] ^ fix_mask_i;
        end else if (host_we_i && !busy_i) begin
            mem[host_addr_i] <= host_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata_o <= '0;
        end else begin
            host_rdata_o <= mem[host_addr_i];
        end
    end

    a_r10_write_only_busy: assert property (@(posedge clk) disable iff (rst)
        fix_we_i |-> busy_i);

endmodule

// File: rtl/rsfix_applier.sv
`timescale 1ns/1ps
module rsfix_applier
    import rsfix_pkg::*;
#(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int ECC_BYTES   = 14,
    parameter int MAX_ERR     = 4,
    parameter int POS_W       = 11,
    localparam int TOTAL      = DATA_BYTES + SPARE_BYTES,
    localparam int AW         = $clog2(TOTAL),
    localparam int CNT_W      = $clog2(MAX_ERR + 1),
    localparam int MAX_POS    = ((DATA_BYTES + ECC_BYTES) * 2) / 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [CNT_W-1:0]          err_cnt_i,
    input  logic [MAX_ERR*POS_W-1:0]  err_pos_i,
    input  logic [MAX_ERR*12-1:0]     err_pat_i,
    input  logic                      host_we_i,
    input  logic [AW-1:0]             host_addr_i,
    input  logic [7:0]                host_wdata_i,
    output logic [7:0]                host_rdata_o,
    output logic                      fix_we_o,
    output logic [AW-1:0]             fix_addr_o,
    output logic [7:0]                fix_mask_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      fail_o,
    output logic [CNT_W-1:0]          corr_cnt_o
);

    logic [CNT_W-1:0]         cnt_q;
    logic [MAX_ERR*POS_W-1:0] pos_q;
    logic [MAX_ERR*SYM_W-1:0] pat_q;
    rsfix_map_t               maps [MAX_ERR];
    logic                     page_bad;

    rsfix_check #(
        .MAX_ERR (MAX_ERR),
        .POS_W   (POS_W),
        .CNT_W   (CNT_W),
        .MAX_POS (MAX_POS)
    ) u_check (
        .cnt_i      (cnt_q),
        .pos_i      (pos_q),
        .pat_i      (pat_q),
        .maps_o     (maps),
        .page_bad_o (page_bad)
    );

    rsfix_ctrl #(
        .MAX_ERR (MAX_ERR),
        .POS_W   (POS_W),
        .CNT_W   (CNT_W),
        .AW      (AW),
        .TOTAL   (TOTAL)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cnt_i      (err_cnt_i),
        .pos_i      (err_pos_i),
        .pat_i      (err_pat_i),
        .cnt_q_o    (cnt_q),
        .pos_q_o    (pos_q),
        .pat_q_o    (pat_q),
        .maps_i     (maps),
        .page_bad_i (page_bad),
        .fix_we_o   (fix_we_o),
        .fix_addr_o (fix_addr_o),
        .fix_mask_o (fix_mask_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .fail_o     (fail_o),
        .corr_cnt_o (corr_cnt_o)
    );

    rsfix_buf #(
        .TOTAL (TOTAL),
        .AW    (AW)
    ) u_buf (
        .clk          (clk),
        .rst          (rst),
        .busy_i       (busy_o),
        .fix_we_i     (fix_we_o),
        .fix_addr_i   (fix_addr_o),
        .fix_mask_i   (fix_mask_o),
        .host_we_i    (host_we_i),
        .host_addr_i  (host_addr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o)
    );

endmodule

// File: tb/tb_rsfix_applier.sv
`timescale 1ns/1ps
module tb_rsfix_applier;

    localparam int D    = 32;
    localparam int S    = 16;
    localparam int E    = 14;
    localparam int ME   = 4;
    localparam int PW   = 6;
    localparam int TOT  = D + S;
    localparam int AW   = 6;
    localparam int CW   = 3;
    localparam int MAXP = ((D + E) * 2) / 3;   // 30
    localparam int BND  = (D * 2) / 3;         // 21

    logic              clk = 1'b0;
    logic              rst;
    logic              start_i;
    logic [CW-1:0]     err_cnt_i;
    logic [ME*PW-1:0]  err_pos_i;
    logic [ME*12-1:0]  err_pat_i;
    logic              host_we_i;
    logic [AW-1:0]     host_addr_i;
    logic [7:0]        host_wdata_i;
    logic [7:0]        host_rdata_o;
    logic              fix_we_o;
    logic [AW-1:0]     fix_addr_o;
    logic [7:0]        fix_mask_o;
    logic              busy_o;
    logic              done_o;
    logic              fail_o;
    logic [CW-1:0]     corr_cnt_o;

    rsfix_applier #(
        .DATA_BYTES (D),
        .SPARE_BYTES(S),
        .ECC_BYTES  (E),
        .MAX_ERR    (ME),
        .POS_W      (PW)
    ) dut (
        .clk, .rst, .start_i, .err_cnt_i, .err_pos_i, .err_pat_i,
        .host_we_i, .host_addr_i, .host_wdata_i, .host_rdata_o,
        .fix_we_o, .fix_addr_o, .fix_mask_o, .busy_o, .done_o,
        .fail_o, .corr_cnt_o
    );

    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] model [TOT];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hwrite(input int a, input logic [7:0] d);
        @(negedge clk);
        host_we_i    = 1'b1;
        host_addr_i  = AW'(a);
        host_wdata_i = d;
        @(negedge clk);
        host_we_i    = 1'b0;
    endtask

    task automatic hread(input int a, output logic [7:0] d);
        @(negedge clk);
        host_addr_i = AW'(a);
        @(negedge clk);
        d = host_rdata_o;
    endtask

    task automatic verify_mem(input string req);
        int bad = 0;
        int first_a = -1;
        int first_v = 0;
        logic [7:0] d;
        for (int i = 0; i < TOT; i++) begin
            hread(i, d);
            if (d !== model[i]) begin
                if (first_a < 0) begin
                    first_a = i;
                    first_v = int'(d);
                end
                bad++;
            end
        end
        chk(bad == 0, req, "buffer bytes differing", bad, 0);
        if (first_a >= 0)
            $display("  first difference at byte %0d: actual %0d expected %0d",
                     first_a, first_v, model[first_a]);
    endtask

    task automatic apply_model(input int p, input int q);
        int b;
        b = (3 * p) / 2;
        if (p == 0) begin
            model[0] = model[0] ^ 8'(q & 'hFF);
        end else if (p % 2 == 1) begin
            model[b]     = model[b] ^ 8'((q >> 4) & 'hFF);
            model[b + 1] = model[b + 1] ^ 8'((q & 'hF) << 4);
        end else begin
            model[b - 1] = model[b - 1] ^ 8'((q >> 8) & 'hF);
            model[b]     = model[b] ^ 8'(q & 'hFF);
        end
    endtask

    task automatic run_page(input int n, input int p[4], input int q[4],
                            input bit poke, input string req);
        bit bad;
        int w;
        int lat;
        int writes;
        bad = (n > ME);
        w = 0;
        for (int i = 0; i < ME; i++) begin
            if (i < n) begin
                if (p[i] > MAXP) bad = 1'b1;
                if (p[i] == 0 && q[i] > 'hFF) bad = 1'b1;
                w += (p[i] == 0) ? 1 : 2;
            end
        end
        if (bad) w = 0;
        else for (int i = 0; i < n; i++) apply_model(p[i], q[i]);

        err_cnt_i = CW'(n);
        for (int i = 0; i < ME; i++) begin
            err_pos_i[i*PW +: PW] = PW'(p[i]);
            err_pat_i[i*12 +: 12] = 12'(q[i]);
        end
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        writes = 0;
        while (!done_o && lat < 100) begin
            if (fix_we_o) writes++;
            if (poke && lat == 2) begin
                host_we_i    = 1'b1;
                host_addr_i  = AW'(1);
                host_wdata_i = ~model[1];
                start_i      = 1'b1;
            end else begin
                host_we_i = 1'b0;
                start_i   = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        host_we_i = 1'b0;
        start_i   = 1'b0;
        chk(done_o == 1'b1, req, "done seen (R9)", int'(done_o), 1);
        chk(lat == w + 2, req, "done latency (R10)", lat, w + 2);
        chk(writes == w, req, "write cycles (R10)", writes, w);
        chk(fail_o == bad, req, "fail flag", int'(fail_o), int'(bad));
        chk(int'(corr_cnt_o) == (bad ? 0 : n), req, "corrected count (R9)",
            int'(corr_cnt_o), bad ? 0 : n);
        @(negedge clk);
        chk(!busy_o && !done_o, req, "idle after single done pulse (R9)",
            int'({busy_o, done_o}), 0);
        verify_mem(poke ? {req, " R11"} : req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        string tag;
        int q;
        rst = 1'b1;
        start_i = 1'b0;
        err_cnt_i = '0;
        err_pos_i = '0;
        err_pat_i = '0;
        host_we_i = 1'b0;
        host_addr_i = '0;
        host_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !fail_o && !fix_we_o, "R1", "status after reset",
            int'({busy_o, done_o, fail_o, fix_we_o}), 0);
        chk(corr_cnt_o == '0, "R1", "count after reset", int'(corr_cnt_o), 0);

        // R12 load and read back the page
        for (int i = 0; i < TOT; i++) begin
            model[i] = 8'((i * 29 + 11) & 'hFF);
            hwrite(i, model[i]);
        end
        verify_mem("R12");

        // R3 symbol 0 in range and out of range
        run_page(1, '{0, 0, 0, 0}, '{'h0A5, 0, 0, 0}, 1'b0, "R3");
        run_page(1, '{0, 0, 0, 0}, '{'h3A5, 0, 0, 0}, 1'b0, "R3");

        // Sweep every position, both sides of the limit
        for (int p = 1; p <= MAXP + 6; p++) begin
            q = (p * 181 + 77) & 'hFFF;
            if (p > MAXP)        tag = "R2";
            else if (p == BND)   tag = "R6";
            else if (p % 2 == 1) tag = "R4";
            else                 tag = "R5";
            run_page(1, '{p, 0, 0, 0}, '{q, 0, 0, 0}, (p % 4 == 1) && (p <= MAXP), tag);
        end

        // Four errors across data, boundary and spare, with busy-time pokes
        run_page(4, '{1, 2, BND, MAXP}, '{'hABC, 'h123, 'hF0F, 'h5A5}, 1'b1, "R10");
        // Overlapping bytes accumulate
        run_page(3, '{4, 4, 5, 0}, '{'h9C3, 'h3D7, 'hE21, 0}, 1'b0, "R13");
        run_page(2, '{0, 1, 0, 0}, '{'h0F0, 'hFFF, 0, 0}, 1'b0, "R13");
        // Empty list
        run_page(0, '{7, 8, 9, 10}, '{'h111, 'h222, 'h333, 'h444}, 1'b0, "R9");
        // Excess count
        run_page(5, '{3, 5, 7, 9}, '{'h111, 'h222, 'h333, 'h444}, 1'b0, "R7");
        // Late bad entry blocks earlier writes
        run_page(4, '{3, 7, MAXP + 1, 9}, '{'h111, 'h222, 'h333, 'h444}, 1'b0, "R8");
        run_page(2, '{5, 0, 0, 0}, '{'h777, 'h100, 0, 0}, 1'b0, "R8");
        // Recovery: a clean job after a failed one
        run_page(2, '{6, 11, 0, 0}, '{'h4B2, 'h8E1, 0, 0}, 1'b0, "R9");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule